// File: doc/BRIEF.md
# Banked Interrupt Controller with Latched NMI

The controller gathers up to 81 interrupt request lines into three 32-bit banks. Source n sits in bank n/32 at bit n%32. Every source passes through two gates before it can become pending: an enable bit that must be 1 and a mask bit that must be 0. A per-source select bit then routes it either to the IRQ pending bank or to the FIQ pending bank. The block drives one `irq_o` and one `fiq_o` line toward a processor. A vector register gives the number of the lowest-numbered pending IRQ source, so that a handler can service sources in a fixed order.

Source 0 is the external non-maskable line, and it behaves differently from the others. Its pending bit latches on a trigger condition chosen by a small control register: high level, low level, rising edge or falling edge. Once set, the bit stays set until software writes a one to bit 0 of IRQ pending bank 0. Sources 1 to 80 are level-following: their pending bits track the gated input one clock later.

Software reaches the block over a plain single-cycle register bus with an address, a write strobe, write data and combinational read data. The bus has no handshake and no back-pressure. A write takes effect at the clock edge where `bus_we` is high, and a read returns data in the same cycle as its address.

Top module: `bankintc_top`

## Requirements
- R1: After reset the registers read as follows. Enable, select and all pending banks read 0. Mask banks 0 and 1 read 0xFFFFFFFF and mask bank 2 reads 0x0001FFFF. Protection, NMI control, base and vector read 0. `irq_o` and `fiq_o` are low.
- R2: Take a source n from 1 to 80 whose enable bit is 1, mask bit is 0 and select bit is 0. Its bit in IRQ pending bank n/32 equals its input level as sampled at the previous clock edge. The banks sit at offsets 0x10, 0x14 and 0x18.
- R3: A source whose mask bit is 1, or whose enable bit is 0, never becomes pending. The enable banks sit at 0x40, 0x44 and 0x48, and the mask banks at 0x50, 0x54 and 0x58.
- R4: A gated source whose select bit is 1 appears in the FIQ pending banks (0x20, 0x24, 0x28) and not in the IRQ pending banks. The select banks sit at 0x30, 0x34 and 0x38, where 1 means FIQ and 0 means IRQ.
- R5: `irq_o` is high exactly when some IRQ pending bit is set. `fiq_o` is high exactly when some FIQ pending bit is set.
- R6: Once the pending bit of source 0 is set, it stays set while its input returns to the inactive state, as long as no clearing write occurs.
- R7: A write to offset 0x10 with bit 0 equal to 1 clears the source-0 pending bit. A write with bit 0 equal to 0 leaves it unchanged. If a trigger condition and a clearing write fall on the same clock edge, the bit stays set.
- R8: NMI control (offset 0x0C, bits [1:0]) selects the source-0 trigger: 0 is high level, 1 is rising edge, 2 is low level and 3 is falling edge. Bits above 1 read as 0.
- R9: The vector register (offset 0x00) reads as the number of the lowest pending IRQ source shifted left by 2. It reads 0 when no IRQ source is pending. Sources pending only in the FIQ banks do not affect it.
- R10: Writes to the pending banks change nothing except bit 0 of IRQ bank 0. Writes to the vector register are ignored.
- R11: Bits 17 to 31 of every bank-2 register (sources 81 to 95) always read 0. Addresses outside the map read 0.
- R12: The protection register (offset 0x08) keeps only bit 0, and its other bits read 0. The base register (offset 0x04) stores and returns all 32 bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| src_i | input | 81 | Interrupt request lines; bit 0 is the external NMI |
| bus_addr | input | 8 | Register byte address |
| bus_we | input | 1 | Write strobe, sampled at the rising clock edge |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr`, combinational |
| irq_o | output | 1 | OR of all IRQ pending bits |
| fiq_o | output | 1 | OR of all FIQ pending bits |

## Verification
Two events can land on the same clock edge: a source-0 trigger and the software write that clears the latch. The bench provokes this in two ways. First, it raises the NMI line in rising-edge mode in the very cycle the write-one to offset 0x10 is strobed. Second, it clears the bit while a level trigger is still active. In both cases it judges the outcome by reading the pending bank afterwards and expects the bit to remain set, so that no event is lost. A later clear with the trigger inactive must then empty the bit.

// File: rtl/bankintc_pkg.sv
package bankintc_pkg;

  // Register byte offsets; bank k of a group lives at group base + 4*k
  localparam int ADR_VEC   = 8'h00;
  localparam int ADR_BASE  = 8'h04;
  localparam int ADR_PROT  = 8'h08;
  localparam int ADR_NMI   = 8'h0C;
  localparam int ADR_IPEND = 8'h10;
  localparam int ADR_FPEND = 8'h20;
  localparam int ADR_SEL   = 8'h30;
  localparam int ADR_EN    = 8'h40;
  localparam int ADR_MASK  = 8'h50;
  localparam int BANK_STEP = 4;

  typedef enum logic [1:0] {
    TRIG_HIGH = 2'd0,
    TRIG_RISE = 2'd1,
    TRIG_LOW  = 2'd2,
    TRIG_FALL = 2'd3
  } nmi_trig_e;

endpackage

// File: rtl/bankintc_regs.sv
module bankintc_regs
  import bankintc_pkg::*;
#(
  parameter int NUM_SRC = 81,
  parameter int DW      = 32,
  parameter int AW      = 8,
  parameter int IDXW    = $clog2(NUM_SRC)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [AW-1:0]      bus_addr,
  input  logic               bus_we,
  input  logic [DW-1:0]      bus_wdata,
  output logic [DW-1:0]      bus_rdata,
  input  logic [NUM_SRC-1:0] irq_pend,
  input  logic [NUM_SRC-1:0] fiq_pend,
  input  logic [IDXW-1:0]    vec_idx,
  output logic [NUM_SRC-1:0] en_q,
  output logic [NUM_SRC-1:0] mask_q,
  output logic [NUM_SRC-1:0] sel_q,
  output nmi_trig_e          nmi_ctl_q,
  output logic               nmi_clr
);

  localparam int NBANK = (NUM_SRC + DW - 1) / DW;
  localparam int PADW  = NBANK * DW;
  localparam int TOPW  = NUM_SRC - (NBANK - 1) * DW;

  function automatic logic [AW-1:0] bank_addr(input int base, input int bank);
    return AW'(base + BANK_STEP * bank);
  endfunction

  logic [DW-1:0]   base_q;
  logic            prot_q;
  logic [PADW-1:0] en_p, mask_p, sel_p, ip_p, fp_p;

  // Write-one to bit 0 of IRQ pending bank 0 releases the NMI latch
  assign nmi_clr = bus_we && (bus_addr == AW'(ADR_IPEND)) && bus_wdata[0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      base_q    <= '0;
      prot_q    <= 1'b0;
      nmi_ctl_q <= TRIG_HIGH;
      en_q      <= '0;
      mask_q    <= '1;
      sel_q     <= '0;
    end else if (bus_we) begin
      if (bus_addr == AW'(ADR_BASE)) base_q    <= bus_wdata;
      if (bus_addr == AW'(ADR_PROT)) prot_q    <= bus_wdata[0];
      if (bus_addr == AW'(ADR_NMI))  nmi_ctl_q <= nmi_trig_e'(bus_wdata[1:0]);
      for (int n = 0; n < NUM_SRC; n++) begin
        if (bus_addr == bank_addr(ADR_EN, n / DW))   en_q[n]   <= bus_wdata[n % DW];
        if (bus_addr == bank_addr(ADR_MASK, n / DW)) mask_q[n] <= bus_wdata[n % DW];
        if (bus_addr == bank_addr(ADR_SEL, n / DW))  sel_q[n]  <= bus_wdata[n % DW];
      end
    end
  end

  // Zero-padded images so unimplemented high bits of the last bank read 0
  always_comb begin
    en_p   = '0; en_p[NUM_SRC-1:0]   = en_q;
    mask_p = '0; mask_p[NUM_SRC-1:0] = mask_q;
    sel_p  = '0; sel_p[NUM_SRC-1:0]  = sel_q;
    ip_p   = '0; ip_p[NUM_SRC-1:0]   = irq_pend;
    fp_p   = '0; fp_p[NUM_SRC-1:0]   = fiq_pend;
  end

  always_comb begin
    bus_rdata = '0;
    if (bus_addr == AW'(ADR_VEC))  bus_rdata = DW'({vec_idx, 2'b00});
    if (bus_addr == AW'(ADR_BASE)) bus_rdata = base_q;
    if (bus_addr == AW'(ADR_PROT)) bus_rdata = DW'(prot_q);
    if (bus_addr == AW'(ADR_NMI))  bus_rdata = DW'(nmi_ctl_q);
    for (int b = 0; b < NBANK; b++) begin
      if (bus_addr == bank_addr(ADR_IPEND, b)) bus_rdata = ip_p[b*DW +: DW];
      if (bus_addr == bank_addr(ADR_FPEND, b)) bus_rdata = fp_p[b*DW +: DW];
      if (bus_addr == bank_addr(ADR_SEL, b))   bus_rdata = sel_p[b*DW +: DW];
      if (bus_addr == bank_addr(ADR_EN, b))    bus_rdata = en_p[b*DW +: DW];
      if (bus_addr == bank_addr(ADR_MASK, b))  bus_rdata = mask_p[b*DW +: DW];
    end
  end

  AST_UNIMPL_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_addr == bank_addr(ADR_MASK, NBANK - 1)) |-> ((bus_rdata >> TOPW) == '0)); // R11

  AST_PROT_ONE_BIT: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_addr == AW'(ADR_PROT)) |-> (bus_rdata[DW-1:1] == '0)); // R12

endmodule

// File: rtl/bankintc_pend.sv
module bankintc_pend
  import bankintc_pkg::*;
#(
  parameter int NUM_SRC = 81
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_SRC-1:0] src_i,
  input  logic [NUM_SRC-1:0] en_q,
  input  logic [NUM_SRC-1:0] mask_q,
  input  logic [NUM_SRC-1:0] sel_q,
  input  nmi_trig_e          nmi_ctl_q,
  input  logic               nmi_clr,
  output logic [NUM_SRC-1:0] irq_pend,
  output logic [NUM_SRC-1:0] fiq_pend
);

  logic [NUM_SRC-1:0] gate;
  logic               nmi_prev, nmi_q, nmi_hit;

  assign gate = en_q & ~mask_q;

  // Source 0: trigger detect and sticky latch; a new event wins over a clear
  always_comb begin
    unique case (nmi_ctl_q)
      TRIG_HIGH: nmi_hit = src_i[0];
      TRIG_RISE: nmi_hit = src_i[0] & ~nmi_prev;
      TRIG_LOW:  nmi_hit = ~src_i[0];
      TRIG_FALL: nmi_hit = ~src_i[0] & nmi_prev;
      default:   nmi_hit = 1'b0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      nmi_prev <= 1'b0;
      nmi_q    <= 1'b0;
    end else begin
      nmi_prev <= src_i[0];
      if (gate[0] && nmi_hit) nmi_q <= 1'b1;
      else if (nmi_clr)       nmi_q <= 1'b0;
    end
  end

  assign irq_pend[0] = nmi_q & ~sel_q[0];
  assign fiq_pend[0] = nmi_q &  sel_q[0];

  // Sources 1..NUM_SRC-1: level-following pending flops, steered by select
  for (genvar n = 1; n < NUM_SRC; n++) begin : g_lvl
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        irq_pend[n] <= 1'b0;
        fiq_pend[n] <= 1'b0;
      end else begin
        irq_pend[n] <= src_i[n] & gate[n] & ~sel_q[n];
        fiq_pend[n] <= src_i[n] & gate[n] &  sel_q[n];
      end
    end
  end

  AST_NMI_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (nmi_q && !nmi_clr) |=> nmi_q); // R6

  AST_NMI_FALL_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(nmi_q) |-> $past(nmi_clr)); // R7

  AST_GATED_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
    (((irq_pend | fiq_pend) & ~$past(gate) & ~NUM_SRC'(1)) == '0)); // R3

  AST_ROUTE_DISJOINT: assert property (@(posedge clk) disable iff (!rst_n)
    ((irq_pend & fiq_pend) == '0)); // R4

endmodule

// File: rtl/bankintc_prio.sv
module bankintc_prio #(
  parameter int NUM_SRC = 81,
  parameter int IDXW    = $clog2(NUM_SRC)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_SRC-1:0] pend,
  output logic [IDXW-1:0]    idx,
  output logic               vld
);

  // Lowest set bit wins: scan downward so the last hit is the smallest index
  always_comb begin
    idx = '0;
    vld = 1'b0;
    for (int i = NUM_SRC - 1; i >= 0; i--) begin
      if (pend[i]) begin
        idx = IDXW'(i);
        vld = 1'b1;
      end
    end
  end

  AST_VEC_LOWEST: assert property (@(posedge clk) disable iff (!rst_n)
    vld |-> (pend[idx] && ((pend & ~({NUM_SRC{1'b1}} << idx)) == '0))); // R9

  AST_VEC_NONE: assert property (@(posedge clk) disable iff (!rst_n)
    !vld |-> (pend == '0 && idx == '0)); // R9

endmodule

// File: rtl/bankintc_top.sv
module bankintc_top
  import bankintc_pkg::*;
#(
  parameter int NUM_SRC = 81,
  parameter int DW      = 32,
  parameter int AW      = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_SRC-1:0] src_i,
  input  logic [AW-1:0]      bus_addr,
  input  logic               bus_we,
  input  logic [DW-1:0]      bus_wdata,
  output logic [DW-1:0]      bus_rdata,
  output logic               irq_o,
  output logic               fiq_o
);

  localparam int IDXW = $clog2(NUM_SRC);

  logic [NUM_SRC-1:0] en_q, mask_q, sel_q, irq_pend, fiq_pend;
  nmi_trig_e          nmi_ctl_q;
  logic               nmi_clr, vec_vld;
  logic [IDXW-1:0]    vec_idx;

  bankintc_regs #(.NUM_SRC(NUM_SRC), .DW(DW), .AW(AW), .IDXW(IDXW)) u_regs (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_we(bus_we),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq_pend(irq_pend),
    .fiq_pend(fiq_pend), .vec_idx(vec_idx), .en_q(en_q), .mask_q(mask_q),
    .sel_q(sel_q), .nmi_ctl_q(nmi_ctl_q), .nmi_clr(nmi_clr)
  );

  bankintc_pend #(.NUM_SRC(NUM_SRC)) u_pend (
    .clk(clk), .rst_n(rst_n), .src_i(src_i), .en_q(en_q), .mask_q(mask_q),
    .sel_q(sel_q), .nmi_ctl_q(nmi_ctl_q), .nmi_clr(nmi_clr),
    .irq_pend(irq_pend), .fiq_pend(fiq_pend)
  );

  bankintc_prio #(.NUM_SRC(NUM_SRC), .IDXW(IDXW)) u_prio (
    .clk(clk), .rst_n(rst_n), .pend(irq_pend), .idx(vec_idx), .vld(vec_vld)
  );

  assign irq_o = |irq_pend;
  assign fiq_o = |fiq_pend;

  AST_IRQ_HAS_VECTOR: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_o == vec_vld)); // R5

  AST_IDLE_VECTOR: assert property (@(posedge clk) disable iff (!rst_n)
    !irq_o |-> (vec_idx == '0)); // R9

endmodule

// File: tb/sim_bankintc_top.sv
`timescale 1ns/1ps
module sim_bankintc_top;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [80:0] src = '0;
  logic [7:0]  addr = '0;
  logic        we = 1'b0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        irq, fiq;
  int          n_run = 0, n_fail = 0;

  always #10 clk = ~clk;

  bankintc_top u0 (
    .clk(clk), .rst_n(rst_n), .src_i(src), .bus_addr(addr), .bus_we(we),
    .bus_wdata(wdata), .bus_rdata(rdata), .irq_o(irq), .fiq_o(fiq)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk); addr = a; wdata = d; we = 1'b1;
    @(negedge clk); we = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] v);
    @(negedge clk); addr = a; #2; v = rdata;
  endtask

  task automatic tick();
    @(negedge clk);
  endtask

  task automatic chk_rd(input string tag, input logic [7:0] a, input logic [31:0] exp);
    logic [31:0] v;
    rd(a, v);
    chk(tag, v, exp);
  endtask

  task automatic all_off();
    src = '0;
    for (int b = 0; b < 3; b++) begin
      wr(8'h40 + 8'(4*b), 32'h0);
      wr(8'h50 + 8'(4*b), 32'hFFFF_FFFF);
      wr(8'h30 + 8'(4*b), 32'h0);
    end
    wr(8'h10, 32'h1);
    tick();
  endtask

  task automatic t_reset();
    chk_rd("R1 vector", 8'h00, 0);
    chk_rd("R1 base", 8'h04, 0);
    chk_rd("R1 prot", 8'h08, 0);
    chk_rd("R1 nmictl", 8'h0C, 0);
    for (int b = 0; b < 3; b++) begin
      chk_rd("R1 ipend", 8'h10 + 8'(4*b), 0);
      chk_rd("R1 fpend", 8'h20 + 8'(4*b), 0);
      chk_rd("R1 sel", 8'h30 + 8'(4*b), 0);
      chk_rd("R1 en", 8'h40 + 8'(4*b), 0);
    end
    chk_rd("R1 mask0", 8'h50, 32'hFFFF_FFFF);
    chk_rd("R1 mask1", 8'h54, 32'hFFFF_FFFF);
    chk_rd("R1 mask2", 8'h58, 32'h0001_FFFF);
    chk("R1 irq_o", 32'(irq), 0);
    chk("R1 fiq_o", 32'(fiq), 0);
  endtask

  task automatic t_level();
    wr(8'h44, 32'h20); wr(8'h54, 32'hFFFF_FFDF);
    @(negedge clk); src[37] = 1'b1;
    tick();
    chk_rd("R2 pend src37", 8'h14, 32'h20);
    chk("R5 irq_o high", 32'(irq), 1);
    chk_rd("R9 vector 37", 8'h00, 37 << 2);
    @(negedge clk); src[37] = 1'b0;
    tick();
    chk_rd("R2 follows low", 8'h14, 0);
    chk("R5 irq_o low", 32'(irq), 0);
  endtask

  task automatic t_mask();
    @(negedge clk); src[37] = 1'b1;
    wr(8'h54, 32'hFFFF_FFFF);
    tick();
    chk_rd("R3 masked though enabled", 8'h14, 0);
    wr(8'h54, 32'hFFFF_FFDF); wr(8'h44, 32'h0);
    tick();
    chk_rd("R3 disabled", 8'h14, 0);
    chk("R3 irq_o", 32'(irq), 0);
    all_off();
  endtask

  task automatic t_fiq();
    wr(8'h40, 32'h20); wr(8'h50, 32'hFFFF_FFDF); wr(8'h30, 32'h20);
    @(negedge clk); src[5] = 1'b1;
    tick();
    chk_rd("R4 fiq bank", 8'h20, 32'h20);
    chk_rd("R4 irq bank clear", 8'h10, 0);
    chk("R5 fiq_o", 32'(fiq), 1);
    chk("R5 irq_o", 32'(irq), 0);
    chk_rd("R9 fiq not vectored", 8'h00, 0);
    all_off();
  endtask

  task automatic t_vector();
    for (int b = 0; b < 3; b++) begin
      wr(8'h40 + 8'(4*b), 32'hFFFF_FFFF);
      wr(8'h50 + 8'(4*b), 32'h0);
    end
    @(negedge clk); src[70] = 1'b1; src[40] = 1'b1;
    tick();
    chk_rd("R9 lowest 40", 8'h00, 40 << 2);
    @(negedge clk); src[33] = 1'b1;
    tick();
    chk_rd("R9 lowest 33", 8'h00, 33 << 2);
    wr(8'h34, 32'h2);
    tick();
    chk_rd("R9 fiq source skipped", 8'h00, 40 << 2);
    @(negedge clk); src[40] = 1'b0;
    tick();
    chk_rd("R9 bank2 source", 8'h00, 70 << 2);
    chk_rd("R2 bank2 bit", 8'h18, 32'h40);
    // R10: pending and vector writes are ignored
    wr(8'h18, 32'h0);
    wr(8'h14, 32'hFFFF_FFFF);
    wr(8'h24, 32'h0);
    wr(8'h00, 32'h0000_0004);
    tick();
    chk_rd("R10 ipend2 kept", 8'h18, 32'h40);
    chk_rd("R10 ipend1 not set", 8'h14, 0);
    chk_rd("R10 fpend1 kept", 8'h24, 32'h2);
    chk_rd("R10 vector kept", 8'h00, 70 << 2);
    @(negedge clk); src = '0;
    tick();
    chk_rd("R9 none pending", 8'h00, 0);
    all_off();
  endtask

  task automatic t_nmi();
    wr(8'h40, 32'h1); wr(8'h50, 32'hFFFF_FFFE);
    // high level
    @(negedge clk); src[0] = 1'b1;
    tick();
    chk_rd("R8 high level sets", 8'h10, 1);
    @(negedge clk); src[0] = 1'b0;
    tick(); tick();
    chk_rd("R6 latch holds", 8'h10, 1);
    chk("R6 irq_o held", 32'(irq), 1);
    chk_rd("R9 nmi vector", 8'h00, 0);
    wr(8'h10, 32'hFFFF_FFFE);
    chk_rd("R7 write zero keeps", 8'h10, 1);
    wr(8'h10, 32'h1);
    chk_rd("R7 write one clears", 8'h10, 0);
    // rising edge
    wr(8'h0C, 32'h1);
    @(negedge clk); src[0] = 1'b1;
    tick();
    chk_rd("R8 rise sets", 8'h10, 1);
    wr(8'h10, 32'h1); tick();
    chk_rd("R8 rise no retrigger while high", 8'h10, 0);
    // low level
    wr(8'h0C, 32'h2);
    @(negedge clk); src[0] = 1'b0;
    tick();
    chk_rd("R8 low level sets", 8'h10, 1);
    wr(8'h10, 32'h1);
    chk_rd("R7 clear vs active level", 8'h10, 1);
    @(negedge clk); src[0] = 1'b1;
    wr(8'h10, 32'h1);
    chk_rd("R7 clear with level gone", 8'h10, 0);
    // falling edge
    wr(8'h0C, 32'h3);
    tick();
    chk_rd("R8 fall idle", 8'h10, 0);
    @(negedge clk); src[0] = 1'b0;
    tick();
    chk_rd("R8 fall sets", 8'h10, 1);
    wr(8'h10, 32'h1);
    chk_rd("R8 fall cleared", 8'h10, 0);
    // race: rising edge and clear on the same edge
    wr(8'h0C, 32'h1);
    tick();
    @(negedge clk); src[0] = 1'b1; addr = 8'h10; wdata = 32'h1; we = 1'b1;
    @(negedge clk); we = 1'b0;
    chk_rd("R7 set wins over clear", 8'h10, 1);
    wr(8'h10, 32'h1);
    chk_rd("R7 later clear", 8'h10, 0);
    chk_rd("R8 ctl upper bits", 8'h0C, 1);
    all_off();
  endtask

  task automatic t_misc();
    wr(8'h48, 32'hFFFF_FFFF);
    chk_rd("R11 en bank2 upper zero", 8'h48, 32'h0001_FFFF);
    wr(8'h38, 32'hFFFF_FFFF);
    chk_rd("R11 sel bank2 upper zero", 8'h38, 32'h0001_FFFF);
    chk_rd("R11 unmapped", 8'h60, 0);
    chk_rd("R11 unmapped gap", 8'h1C, 0);
    wr(8'h08, 32'hFFFF_FFFF);
    chk_rd("R12 prot bit0 only", 8'h08, 1);
    wr(8'h04, 32'h1234_5678);
    chk_rd("R12 base", 8'h04, 32'h1234_5678);
    wr(8'h0C, 32'hFFFF_FFFF);
    chk_rd("R8 ctl width", 8'h0C, 3);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_level();
    t_mask();
    t_fiq();
    t_vector();
    t_nmi();
    t_misc();
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

endmodule